// File: doc/BRIEF.md
# Dual-Source Serial Baud Generator

This block produces the bit-rate timing for an asynchronous serial port from one input clock. The receive side and the transmit side each have their own settings and each chooses between two ways of dividing the clock. The first is a fixed-ratio divider chain: a small prescaler followed by a power-of-two range stage, which reaches the usual standard rates from standard clock frequencies. The second is a programmable integer divisor, which reaches useful rates from non-standard clocks.

Each direction divides the clock down to a rate tick that runs at sixteen times its bit rate. The receive output is that rate tick itself, used by a receiver to oversample its input. The transmit output divides its own rate tick by sixteen again, giving one pulse per transmitted bit. When a direction's settings change, only that direction's counters restart, and they restart cleanly. The periods are exact integer numbers of clocks, so rate accuracy depends only on which divisor is chosen.

Top module: `baud_gen`

## Requirements
- R1: With the programmable path selected and a divisor D from 1 to 255, the rate tick of that direction is a one-clock pulse every D clocks.
- R2: With the fixed-ratio path selected, the rate-tick period is F × 2^S clocks. F comes from the 2-bit prescaler code (0 gives 1, 1 gives 3, 2 gives 4, 3 gives 13) and S is the 3-bit range code (0 to 7).
- R3: `rxTick` is the receive rate tick. `txTick` pulses once for every 16 transmit rate ticks, so its period is 16 times the transmit rate period.
- R4: Receive and transmit settings may differ at the same time, and each output follows only its own settings. Changing one direction's settings does not move the other direction's tick times.
- R5: A direction with the programmable path selected and a divisor of 0 emits no ticks on its output for as long as that setting is held.
- R6: At a clock edge where a direction's settings differ from those of the previous cycle, that direction restarts. Its output is low in the following cycle. Its first new tick comes exactly one period later (16 rate periods for `txTick`), counted from that edge.
- R7: Reset is synchronous and active low. Both outputs are low while reset is held. The first tick comes one full period after the last clock edge at which reset was sampled low.
- R8: `txTick` is never high in two consecutive cycles. `rxTick` is high in consecutive cycles only when the receive period is one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that all rates are divided from |
| rstN | input | 1 | Synchronous reset, active low |
| rxUseProg | input | 1 | Receive: 1 selects the programmable divisor, 0 the fixed-ratio chain |
| rxDivisor | input | 8 | Receive programmable divisor; 0 stops ticks |
| rxPreSel | input | 2 | Receive fixed-chain prescaler code |
| rxRangeSel | input | 3 | Receive fixed-chain power-of-two range code |
| txUseProg | input | 1 | Transmit: 1 selects the programmable divisor, 0 the fixed-ratio chain |
| txDivisor | input | 8 | Transmit programmable divisor; 0 stops ticks |
| txPreSel | input | 2 | Transmit fixed-chain prescaler code |
| txRangeSel | input | 3 | Transmit fixed-chain power-of-two range code |
| rxTick | output | 1 | Receive rate tick, 16 times the receive bit rate |
| txTick | output | 1 | Transmit bit tick |

## Verification
A counter left at a wrong value shifts the phase or the spacing of a tick. This shows within one period of the affected direction: as early as the next cycle for short divisors, and up to 16 × 13 × 128 clocks for the slowest transmit setting. A restart that is missed or that leaks into the other direction moves every later tick of one output by a fixed offset, so the first tick after a settings change shows it. A wrong prescaler code map or range shift gives a wrong constant spacing from the first interval on.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Configuration field widths
  localparam int DIV_W     = 8;
  localparam int PRE_W     = 2;
  localparam int RANGE_W   = 3;

  // Counter widths derived from the fields
  localparam int PRE_CNT_W = 4;                    // holds the largest prescale factor (13)
  localparam int RNG_CNT_W = (1 << RANGE_W) - 1;   // holds 2^(2^RANGE_W - 1) - 1

  // Direction indices
  localparam int NDIR   = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  typedef struct packed {
    logic                 useProg;
    logic [DIV_W-1:0]     divisor;
    logic [PRE_W-1:0]     preSel;
    logic [RANGE_W-1:0]   rangeSel;
  } dirCfg_t;

  // Strobes from the control to one direction's datapath
  typedef struct packed {
    logic restart;   // clear all counters this cycle, no tick
    logic run;       // settings in force produce ticks
  } dirStrobe_t;

  // Fixed-chain prescaler code to divide factor
  function automatic logic [PRE_CNT_W-1:0] preFactor(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    return PRE_CNT_W'(1);
      2'd1:    return PRE_CNT_W'(3);
      2'd2:    return PRE_CNT_W'(4);
      default: return PRE_CNT_W'(13);
    endcase
  endfunction

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_gen_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dirCfg_t [NDIR-1:0]    cfgIn,
  output dirCfg_t [NDIR-1:0]    cfgQ,
  output dirStrobe_t [NDIR-1:0] strb
);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic cfgChanged;

    // Settings in force: always the previous cycle's inputs
    always_ff @(posedge clk) begin
      cfgQ[d] <= cfgIn[d];
    end

    assign cfgChanged = (cfgIn[d] != cfgQ[d]);

    always_comb begin
      strb[d].restart = !rstN || cfgChanged;
      strb[d].run     = !(cfgQ[d].useProg && (cfgQ[d].divisor == '0));
    end
  end

endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_gen_pkg::*;
#(
  parameter int POST_DIV = 1
)(
  input  logic       clk,
  input  dirStrobe_t strb,
  input  dirCfg_t    cfgQ,
  output logic       tick
);

  logic [DIV_W-1:0]     progCnt;
  logic [PRE_CNT_W-1:0] preCnt;
  logic [PRE_CNT_W-1:0] preLast;
  logic [RNG_CNT_W-1:0] rngCnt;
  logic [RNG_CNT_W-1:0] rngLast;
  logic                 progHit;
  logic                 preHit;
  logic                 rngHit;
  logic                 rateHit;

  always_comb begin
    progHit = (progCnt == (cfgQ.divisor - DIV_W'(1)));
    preLast = preFactor(cfgQ.preSel) - PRE_CNT_W'(1);
    preHit  = (preCnt == preLast);
    rngLast = ~({RNG_CNT_W{1'b1}} << cfgQ.rangeSel);
    rngHit  = preHit && (rngCnt == rngLast);
    rateHit = strb.run && (cfgQ.useProg ? progHit : rngHit);
  end

  // Programmable divisor path
  always_ff @(posedge clk) begin
    if (strb.restart) begin
      progCnt <= '0;
    end else if (strb.run && cfgQ.useProg) begin
      progCnt <= progHit ? '0 : progCnt + DIV_W'(1);
    end
  end

  // Fixed-ratio chain: prescaler, then power-of-two range stage
  always_ff @(posedge clk) begin
    if (strb.restart) begin
      preCnt <= '0;
      rngCnt <= '0;
    end else if (strb.run && !cfgQ.useProg) begin
      preCnt <= preHit ? '0 : preCnt + PRE_CNT_W'(1);
      if (preHit) begin
        rngCnt <= (rngCnt == rngLast) ? '0 : rngCnt + RNG_CNT_W'(1);
      end
    end
  end

  if (POST_DIV == 1) begin : g_direct
    always_ff @(posedge clk) begin
      tick <= !strb.restart && rateHit;
    end
  end else begin : g_post
    localparam int POST_W = $clog2(POST_DIV);
    logic [POST_W-1:0] postCnt;
    logic              postHit;

    assign postHit = (postCnt == POST_W'(POST_DIV - 1));

    always_ff @(posedge clk) begin
      if (strb.restart) begin
        postCnt <= '0;
        tick    <= 1'b0;
      end else begin
        if (rateHit) begin
          postCnt <= postHit ? '0 : postCnt + POST_W'(1);
        end
        tick <= rateHit && postHit;
      end
    end
  end

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int OVERSAMPLE = 16
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxUseProg,
  input  logic [DIV_W-1:0]   rxDivisor,
  input  logic [PRE_W-1:0]   rxPreSel,
  input  logic [RANGE_W-1:0] rxRangeSel,
  input  logic               txUseProg,
  input  logic [DIV_W-1:0]   txDivisor,
  input  logic [PRE_W-1:0]   txPreSel,
  input  logic [RANGE_W-1:0] txRangeSel,
  output logic               rxTick,
  output logic               txTick
);

  dirCfg_t    [NDIR-1:0] cfgIn;
  dirCfg_t    [NDIR-1:0] cfgQ;
  dirStrobe_t [NDIR-1:0] strb;
  logic       [NDIR-1:0] tickOut;

  assign cfgIn[DIR_RX] = {rxUseProg, rxDivisor, rxPreSel, rxRangeSel};
  assign cfgIn[DIR_TX] = {txUseProg, txDivisor, txPreSel, txRangeSel};

  baud_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .cfgIn (cfgIn),
    .cfgQ  (cfgQ),
    .strb  (strb)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_path
    baud_dp #(
      .POST_DIV ((d == DIR_TX) ? OVERSAMPLE : 1)
    ) u_dp (
      .clk  (clk),
      .strb (strb[d]),
      .cfgQ (cfgQ[d]),
      .tick (tickOut[d])
    );
  end

  assign rxTick = tickOut[DIR_RX];
  assign txTick = tickOut[DIR_TX];

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
  import baud_gen_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               rxUseProg,
  input logic [DIV_W-1:0]   rxDivisor,
  input logic [PRE_W-1:0]   rxPreSel,
  input logic [RANGE_W-1:0] rxRangeSel,
  input logic               txUseProg,
  input logic [DIV_W-1:0]   txDivisor,
  input logic [PRE_W-1:0]   txPreSel,
  input logic [RANGE_W-1:0] txRangeSel,
  input logic               rxTick,
  input logic               txTick
);

  localparam int GAP_W = 10;

  logic [$bits(dirCfg_t)-1:0] rxBus, txBus, rxBusPrev;
  logic [GAP_W-1:0]           rxGap;

  assign rxBus = {rxUseProg, rxDivisor, rxPreSel, rxRangeSel};
  assign txBus = {txUseProg, txDivisor, txPreSel, txRangeSel};

  // Clocks since the last receive restart (0) or receive tick (1)
  always_ff @(posedge clk) begin
    rxBusPrev <= rxBus;
    if (!rstN || (rxBus != rxBusPrev)) begin
      rxGap <= '0;
    end else if (rxTick) begin
      rxGap <= GAP_W'(1);
    end else if (rxGap != {GAP_W{1'b1}}) begin
      rxGap <= rxGap + GAP_W'(1);
    end
  end

  // R1
  prog_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxTick && rxUseProg && (rxBus == rxBusPrev)) |-> (rxGap == GAP_W'(rxDivisor)));

  // R5
  rx_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxUseProg && (rxDivisor == '0) && $stable(rxBus)) |=> !rxTick);

  // R5
  tx_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txUseProg && (txDivisor == '0) && $stable(txBus)) |=> !txTick);

  // R6
  rx_restart_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxBus != $past(rxBus)) |=> !rxTick);

  // R6
  tx_restart_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBus != $past(txBus)) |=> !txTick);

  // R8
  tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTick |=> !txTick);

endmodule

bind baud_gen baud_gen_chk u_chk (.*);

// File: tb/baud_gen_bench.sv
module baud_gen_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rxUseProg, txUseProg;
  logic [7:0] rxDivisor, txDivisor;
  logic [1:0] rxPreSel, txPreSel;
  logic [2:0] rxRangeSel, txRangeSel;
  logic       rxTick, txTick;

  always #5 clk = ~clk;

  baud_gen u_baud_gen (
    .clk(clk), .rstN(rstN),
    .rxUseProg(rxUseProg), .rxDivisor(rxDivisor), .rxPreSel(rxPreSel), .rxRangeSel(rxRangeSel),
    .txUseProg(txUseProg), .txDivisor(txDivisor), .txPreSel(txPreSel), .txRangeSel(txRangeSel),
    .rxTick(rxTick), .txTick(txTick)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    nChecks = 0, nFail = 0;
  bit    done = 0;
  int    rxQt[$], txQt[$];
  string rxQr[$], txQr[$];
  string rxTagNow = "R7", txTagNow = "R7";
  int    rxSeen = 0, txSeen = 0;
  logic [13:0] rxCur, txCur;
  int    rxBase, txBase;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(input bit useProg, input int dv, input int pre, input int rng);
    return {useProg, 8'(dv), 2'(pre), 3'(rng)};
  endfunction

  // Rate period in clocks from the requirements (0 = no ticks)
  function automatic int ratePeriod(input logic [13:0] c);
    int f;
    if (c[13]) return int'(c[12:5]);
    case (c[4:3])
      2'd0: f = 1;
      2'd1: f = 3;
      2'd2: f = 4;
      default: f = 13;
    endcase
    return f << c[2:0];
  endfunction

  // Monitor: pops expected tick times and compares
  always @(negedge clk) begin
    if (!done) begin
      while (rxQt.size() > 0 && rxQt[0] < cyc) begin
        check(0, rxQr[0], "rx tick missing at cycle", 0, rxQt[0]);
        void'(rxQt.pop_front()); void'(rxQr.pop_front());
      end
      while (txQt.size() > 0 && txQt[0] < cyc) begin
        check(0, txQr[0], "tx tick missing at cycle", 0, txQt[0]);
        void'(txQt.pop_front()); void'(txQr.pop_front());
      end
      if (rxTick === 1'b1) begin
        rxSeen++;
        if (rxQt.size() > 0 && rxQt[0] == cyc) begin
          check(1, rxQr[0], "rx tick time", cyc, cyc);
          void'(rxQt.pop_front()); void'(rxQr.pop_front());
        end else check(0, rxTagNow, "rx unexpected tick at cycle", cyc, -1);
      end
      if (txTick === 1'b1) begin
        txSeen++;
        if (txQt.size() > 0 && txQt[0] == cyc) begin
          check(1, txQr[0], "tx tick time", cyc, cyc);
          void'(txQt.pop_front()); void'(txQr.pop_front());
        end else check(0, txTagNow, "tx unexpected tick at cycle", cyc, -1);
      end
    end
  end

  // Driver: applies settings, pushes expected ticks for the window, checks counts
  task automatic phase(input logic [13:0] rxC, input logic [13:0] txC, input int w,
                       input string rxTag, input string txTag, input bit fromReset);
    int c, p, rxExp, txExp;
    c = cyc;
    if (fromReset) begin
      rxBase = c; txBase = c; rxCur = rxC; txCur = txC;
      rstN = 1'b1;
    end else begin
      if (rxC != rxCur) begin rxBase = c + 1; rxCur = rxC; end
      if (txC != txCur) begin txBase = c + 1; txCur = txC; end
    end
    {rxUseProg, rxDivisor, rxPreSel, rxRangeSel} = rxC;
    {txUseProg, txDivisor, txPreSel, txRangeSel} = txC;
    rxTagNow = rxTag; txTagNow = txTag;
    rxSeen = 0; txSeen = 0; rxExp = 0; txExp = 0;
    p = ratePeriod(rxCur);
    if (p > 0) for (int t = rxBase + p; t <= c + w; t += p)
      if (t >= c + 1) begin rxQt.push_back(t); rxQr.push_back(rxTag); rxExp++; end
    p = 16 * ratePeriod(txCur);
    if (p > 0) for (int t = txBase + p; t <= c + w; t += p)
      if (t >= c + 1) begin txQt.push_back(t); txQr.push_back(txTag); txExp++; end
    repeat (w) @(negedge clk);
    #1;
    check(rxSeen == rxExp, rxTag, "rx tick count in window", rxSeen, rxExp);
    check(txSeen == txExp, txTag, "tx tick count in window", txSeen, txExp);
  endtask

  initial begin
    rstN = 1'b0;
    {rxUseProg, rxDivisor, rxPreSel, rxRangeSel} = mk(1, 5, 0, 0);
    {txUseProg, txDivisor, txPreSel, txRangeSel} = mk(1, 3, 0, 0);
    repeat (4) @(negedge clk);
    #1;
    check(rxTick == 1'b0, "R7", "rxTick during reset", int'(rxTick), 0);
    check(txTick == 1'b0, "R7", "txTick during reset", int'(txTick), 0);
    phase(mk(1, 5, 0, 0), mk(1, 3, 0, 0), 200, "R7", "R3", 1);
    phase(mk(1, 1, 0, 0), mk(0, 0, 0, 2), 150, "R1", "R2 R8", 0);
    phase(mk(0, 0, 3, 1), mk(0, 0, 0, 2), 200, "R2", "R4", 0);
    phase(mk(1, 255, 0, 0), mk(0, 0, 0, 2), 600, "R1", "R4", 0);
    phase(mk(1, 0, 0, 0), mk(0, 0, 1, 3), 800, "R5", "R2", 0);
    phase(mk(0, 0, 2, 7), mk(1, 2, 0, 0), 1100, "R2", "R3", 0);
    phase(mk(0, 0, 2, 7), mk(1, 0, 0, 0), 600, "R4", "R5", 0);
    phase(mk(1, 7, 0, 0), mk(1, 1, 0, 0), 4, "R6", "R6", 0);
    phase(mk(1, 9, 0, 0), mk(1, 1, 0, 0), 4, "R6", "R4", 0);
    phase(mk(1, 6, 0, 0), mk(1, 1, 1, 0), 100, "R6", "R6", 0);
    phase(mk(1, 6, 0, 0), mk(1, 1, 1, 0), 20, "R8", "R8", 0);
    done = 1;
    check(rxQt.size() == 0, "R6", "rx expected ticks left", rxQt.size(), 0);
    check(txQt.size() == 0, "R6", "tx expected ticks left", txQt.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #2000000;
    done = 1;
    check(0, "R7", "watchdog expired at cycle", cyc, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule